// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM Core

This block is a synthesizable model of a synchronous static memory. The address, the control inputs and the write data are captured on a rising clock edge. Read data passes through one more register before it reaches the output. A read whose address is captured on edge N therefore shows its data after edge N+1.

An access can start from either of two active-low strobes. The processor strobe always starts a read. The controller strobe starts a read or a write, chosen by the write controls sampled on that same edge. Once an access has started, cycles in which both strobes are HIGH continue the burst. The advance input steps a two-bit in-burst counter. The counter follows either a wrapping linear order or an interleaved (XOR) order, chosen by a mode input. Writes go to all four bytes at once through a global enable, or to selected bytes through a byte-write enable together with per-byte enables. A write command on a non-processor-strobe edge suppresses the read data leaving the pipeline on that edge.

The block is meant for a small behavioural memory in a larger design or bench. It offers separate input and output data buses and a valid flag in place of a bidirectional pad.

Top module: `sram_pipe_burst`

## Requirements
- R1: A read accepted on rising edge N presents its word on `rdata`, with `rvalid` HIGH, between edge N+1 and edge N+2.
- R2: `adspN` LOW with both chip enables active starts a read of `addr`. It writes nothing, whatever `gwN`, `bweN`, `bwN` and `adscN` hold.
- R3: A write with `gwN` LOW stores all four bytes of `wdata`, whatever `bwN` holds.
- R4: With `gwN` HIGH and `bweN` LOW, only the bytes whose `bwN` bit is LOW are stored. Bit i covers `wdata[8i+7:8i]`. With `gwN` and `bweN` both HIGH, nothing is stored.
- R5: `adscN` starts an access only when `adspN` is HIGH on the same edge. When both strobes are LOW, the edge is handled as a processor-strobe start, which is a read.
- R6: `adspN` LOW while `ce0N` is HIGH causes no access and leaves a burst in progress unchanged. `adscN` is not blocked by `ce0N` in this way.
- R7: With `burstLinear` HIGH, each continue edge with `advN` LOW moves the two low address bits to (start + count) mod 4. The upper bits stay fixed.
- R8: With `burstLinear` LOW, the two low address bits follow start XOR count.
- R9: A continue edge with `advN` HIGH accesses the current burst address again.
- R10: On an edge where `adspN` is HIGH and a write command is present, the read word leaving the pipeline on that edge is suppressed. A write command is `gwN` LOW, or `bweN` LOW with some `bwN` bit LOW.
- R11: While `oeN` is HIGH, `rvalid` is LOW and `rdata` is zero.
- R12: A controller-strobe edge with either chip enable inactive deselects the block. So does a processor-strobe edge with `ce0N` LOW and `ceAuxN` HIGH. A deselect ends the burst, and later continue edges make no access.
- R13: During and right after reset, `rvalid` is LOW and no burst is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset of control and pipeline state |
| adspN | input | 1 | Processor start strobe, active low |
| adscN | input | 1 | Controller start strobe, active low |
| advN | input | 1 | Burst advance, active low |
| ce0N | input | 1 | Master chip enable, active low |
| ceAuxN | input | 1 | Second chip enable, active low |
| gwN | input | 1 | Global write enable, active low |
| bweN | input | 1 | Byte-write enable, active low |
| bwN | input | 4 | Per-byte write enables, active low, bit i for byte i |
| oeN | input | 1 | Output enable, active low |
| burstLinear | input | 1 | 1 selects linear burst order, 0 selects interleaved |
| addr | input | AW | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid |

## Verification
The assertions check the per-edge rules on every cycle. A processor-strobe edge never produces a write. A processor-strobe edge blocked by `ce0N` produces no access. No byte is written without a write enable. A deselect clears the burst. Valid output always traces back to a read two edges earlier, and it is never raised while `oeN` is HIGH or after a write-command edge. Only the bench scenarios can show that the correct bytes land at the correct addresses. The same holds for the linear and interleaved burst orders, and for a blocked processor strobe leaving a burst able to resume. The bench checks all of these against a model that follows the requirements.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int BYTES   = 4;
  localparam int BYTE_W  = 8;
  localparam int DATA_W  = BYTES * BYTE_W;
  localparam int BURST_W = 2;

  typedef struct packed {
    logic             rdEn;
    logic             wrEn;
    logic [BYTES-1:0] byteWr;
    logic             outOff;
  } memStrobes_t;
endpackage

// File: rtl/sram_burst_ctrl.sv
module sram_burst_ctrl
  import sram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 adspN,
  input  logic                 adscN,
  input  logic                 advN,
  input  logic                 ce0N,
  input  logic                 ceAuxN,
  input  logic                 gwN,
  input  logic                 bweN,
  input  logic [BYTES-1:0]     bwN,
  input  logic                 burstLinear,
  input  logic [AW-1:0]        addr,
  output memStrobes_t          strb,
  output logic [AW-1:0]        accAddr
);
  logic               burstOn;
  logic [AW-1:0]      baseAddr;
  logic [BURST_W-1:0] cnt;

  logic procLow, ctrlLow, allOn;
  logic procStart, procDesel, ctrlStart, ctrlDesel, contCyc, anyStart;
  logic wrCmd;
  logic [BYTES-1:0]   byteSel;
  logic [BURST_W-1:0] nextCnt, seqLow;

  always_comb begin
    procLow   = !adspN;
    ctrlLow   = !adscN && adspN;
    allOn     = !ce0N && !ceAuxN;
    procStart = procLow && allOn;
    procDesel = procLow && !ce0N && ceAuxN;
    ctrlStart = ctrlLow && allOn;
    ctrlDesel = ctrlLow && !allOn;
    anyStart  = procStart || ctrlStart;
    contCyc   = adspN && adscN && burstOn;
    wrCmd     = !gwN || (!bweN && !(&bwN));
    if (!gwN)       byteSel = '1;
    else if (!bweN) byteSel = ~bwN;
    else            byteSel = '0;
    nextCnt = (contCyc && !advN) ? cnt + 1'b1 : cnt;
    if (burstLinear) seqLow = baseAddr[BURST_W-1:0] + nextCnt;
    else             seqLow = baseAddr[BURST_W-1:0] ^ nextCnt;
    accAddr = anyStart ? addr : {baseAddr[AW-1:BURST_W], seqLow};
    strb.rdEn   = procStart || ((ctrlStart || contCyc) && !wrCmd);
    strb.wrEn   = (ctrlStart || contCyc) && wrCmd;
    strb.byteWr = strb.wrEn ? byteSel : '0;
    strb.outOff = !procLow && wrCmd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstOn  <= 1'b0;
      baseAddr <= '0;
      cnt      <= '0;
    end else if (anyStart) begin
      burstOn  <= 1'b1;
      baseAddr <= addr;
      cnt      <= '0;
    end else if (procDesel || ctrlDesel) begin
      burstOn  <= 1'b0;
    end else if (contCyc) begin
      cnt      <= nextCnt;
    end
  end

  AST_PROC_READ_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !adspN |-> !strb.wrEn); // R2
  AST_BLOCKED_PROC: assert property (@(posedge clk) disable iff (!rstN)
    (!adspN && ce0N) |-> !(strb.rdEn || strb.wrEn)); // R6
  AST_NO_ENABLE_NO_BYTES: assert property (@(posedge clk) disable iff (!rstN)
    (gwN && bweN) |-> (strb.byteWr == '0)); // R4
  AST_DESEL_ENDS_BURST: assert property (@(posedge clk) disable iff (!rstN)
    (!adscN && adspN && ceAuxN) |=> !burstOn); // R12
endmodule

// File: rtl/sram_array_pipe.sv
module sram_array_pipe
  import sram_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobes_t       strb,
  input  logic [AW-1:0]     accAddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              oeN,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     rdAddrQ;
  logic              rdValidQ;
  logic              rvalidQ;
  logic [DATA_W-1:0] rdataQ;

  always_ff @(posedge clk) begin
    for (int b = 0; b < BYTES; b++) begin
      if (strb.byteWr[b]) mem[accAddr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
    end
    rdataQ <= mem[rdAddrQ];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdAddrQ  <= '0;
      rdValidQ <= 1'b0;
      rvalidQ  <= 1'b0;
    end else begin
      rdAddrQ  <= accAddr;
      rdValidQ <= strb.rdEn;
      rvalidQ  <= rdValidQ && !strb.outOff;
    end
  end

  always_comb begin
    rvalid = rvalidQ && !oeN;
    rdata  = rvalid ? rdataQ : '0;
  end

  AST_OE_BLANKS: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> !rvalid); // R11
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    rvalid |-> $past(strb.rdEn, 2)); // R1
  AST_WRITE_MUTES: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.outOff) |-> !rvalidQ); // R10
endmodule

// File: rtl/sram_pipe_burst.sv
module sram_pipe_burst
  import sram_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              adspN,
  input  logic              adscN,
  input  logic              advN,
  input  logic              ce0N,
  input  logic              ceAuxN,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [BYTES-1:0]  bwN,
  input  logic              oeN,
  input  logic              burstLinear,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  memStrobes_t   strb;
  logic [AW-1:0] accAddr;

  sram_burst_ctrl #(.AW(AW)) uCtrl (
    .clk(clk), .rstN(rstN), .adspN(adspN), .adscN(adscN), .advN(advN),
    .ce0N(ce0N), .ceAuxN(ceAuxN), .gwN(gwN), .bweN(bweN), .bwN(bwN),
    .burstLinear(burstLinear), .addr(addr), .strb(strb), .accAddr(accAddr)
  );

  sram_array_pipe #(.DEPTH(DEPTH), .AW(AW)) uPipe (
    .clk(clk), .rstN(rstN), .strb(strb), .accAddr(accAddr), .wdata(wdata),
    .oeN(oeN), .rdata(rdata), .rvalid(rvalid)
  );
endmodule

// File: tb/tb_sram_pipe_burst.sv
module tb_sram_pipe_burst;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic adspN = 1'b1, adscN = 1'b1, advN = 1'b1, ce0N = 1'b0, ceAuxN = 1'b1;
  logic gwN = 1'b1, bweN = 1'b1, oeN = 1'b0, burstLinear = 1'b1;
  logic [3:0] bwN = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rvalid;

  int checks = 0, errors = 0, edgeCnt = 0;
  bit done = 0;

  typedef struct { int due; bit valid; logic [31:0] data; string tag; } exp_t;
  exp_t q[$];

  logic [31:0] refMem [DEPTH];
  bit mOn = 0;
  int mBase = 0, mCnt = 0;

  sram_pipe_burst #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .adspN(adspN), .adscN(adscN), .advN(advN),
    .ce0N(ce0N), .ceAuxN(ceAuxN), .gwN(gwN), .bweN(bweN), .bwN(bwN),
    .oeN(oeN), .burstLinear(burstLinear), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: pops the item due after each edge and compares
  always begin
    @(posedge clk);
    edgeCnt++;
    #(CLK_PERIOD/4);
    while (q.size() > 0 && q[0].due <= edgeCnt) begin
      exp_t e;
      bit ev;
      logic [31:0] ed;
      e = q.pop_front();
      ev = e.valid && !oeN;
      ed = ev ? e.data : 32'h0;
      checks++;
      if (rvalid !== ev || rdata !== ed) begin
        errors++;
        $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                 e.tag, rvalid, rdata, ev, ed);
      end
    end
  end

  task automatic step(input string tag, input bit aP, input bit aC, input bit adv,
                      input bit c0, input bit cA, input bit gw, input bit bwe,
                      input logic [3:0] bw, input int ad, input logic [31:0] wd);
    bit wrCmd, rd, wr;
    logic [3:0] mask;
    int a;
    exp_t e;
    @(negedge clk);
    adspN = aP; adscN = aC; advN = adv; ce0N = c0; ceAuxN = cA;
    gwN = gw; bweN = bwe; bwN = bw; addr = ad[AW-1:0]; wdata = wd;
    wrCmd = !gw || (!bwe && bw != 4'hF);
    mask = !gw ? 4'hF : (!bwe ? ~bw : 4'h0);
    rd = 0; wr = 0; a = 0;
    if (!aP) begin
      if (!c0) begin
        if (!cA) begin mOn = 1; mBase = ad; mCnt = 0; rd = 1; a = ad; end
        else mOn = 0;
      end
    end else if (!aC) begin
      if (!c0 && !cA) begin
        mOn = 1; mBase = ad; mCnt = 0; a = ad;
        if (wrCmd) wr = 1; else rd = 1;
      end else mOn = 0;
    end else if (mOn) begin
      int low;
      if (!adv) mCnt = (mCnt + 1) % 4;
      low = burstLinear ? (mBase + mCnt) % 4 : ((mBase ^ mCnt) & 3);
      a = (mBase & ~3) | low;
      if (wrCmd) wr = 1; else rd = 1;
    end
    if (aP && wrCmd && q.size() > 0) q[$].valid = 0;  // R10 muting
    e.due = edgeCnt + 2; e.valid = rd; e.data = rd ? refMem[a] : 32'h0; e.tag = tag;
    q.push_back(e);
    if (wr) for (int b = 0; b < 4; b++)
      if (mask[b]) refMem[a][b*8 +: 8] = wd[b*8 +: 8];
  endtask

  task automatic wrC(input string tag, input int ad, input bit gw, input bit bwe,
                     input logic [3:0] bw, input logic [31:0] wd);
    step(tag, 1, 0, 1, 0, 0, gw, bwe, bw, ad, wd);
  endtask
  task automatic rdP(input string tag, input int ad);
    step(tag, 0, 1, 1, 0, 0, 1, 1, 4'hF, ad, 0);
  endtask
  task automatic cont(input string tag, input bit adv);
    step(tag, 1, 1, adv, 0, 0, 1, 1, 4'hF, 0, 0);
  endtask
  task automatic nop();
    step("R12", 1, 0, 1, 0, 1, 1, 1, 4'hF, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) refMem[i] = 32'h0;
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (rvalid !== 1'b0) begin
        errors++;
        $display("FAIL R13: rvalid=%0b expected 0", rvalid);
      end
    end
    @(negedge clk); rstN = 1'b1;
    nop(); nop();  // R13: no read after reset

    // R3: global write ignores bwN
    wrC("R3", 5, 0, 1, 4'hF, 32'hA1B2C3D4);
    nop();
    rdP("R1", 5); nop(); nop();
    // R4: byte writes (bytes 0 and 2)
    wrC("R4", 5, 1, 0, 4'b1010, 32'h11223344);
    nop(); rdP("R4", 5); nop();
    // R4: bweN high -> nothing stored
    wrC("R4", 5, 1, 1, 4'h0, 32'hFFFFFFFF);
    nop(); rdP("R4", 5); nop();
    // R2: processor strobe with write enables and adscN low reads only
    step("R2", 0, 0, 1, 0, 0, 0, 0, 4'h0, 5, 32'hDEADBEEF);
    nop(); rdP("R2", 5); nop();
    // R5: both strobes low -> read path, no write
    step("R5", 0, 0, 1, 0, 0, 0, 1, 4'hF, 6, 32'h55555555);
    nop(); rdP("R5", 6); nop();

    // fill 8..11, plus 12..15 via a write burst (R7 continue writes)
    burstLinear = 1'b1;
    for (int i = 8; i < 12; i++) begin wrC("R3", i, 0, 1, 4'hF, 32'h100 + i); nop(); end
    wrC("R7", 12, 0, 1, 4'hF, 32'h0C0C0C0C);
    step("R7", 1, 1, 0, 0, 0, 0, 1, 4'hF, 0, 32'h0D0D0D0D);
    step("R7", 1, 1, 0, 0, 0, 1, 0, 4'h0, 0, 32'h0E0E0E0E);
    step("R7", 1, 1, 0, 0, 0, 0, 1, 4'hF, 0, 32'h0F0F0F0F);
    nop();
    // R7 linear read burst starting at 9
    rdP("R7", 9); cont("R7", 0); cont("R7", 0); cont("R7", 0); nop();
    rdP("R7", 13); cont("R7", 0); cont("R7", 0); cont("R7", 0); nop();
    // R8 interleaved from 9: 9,8,11,10
    burstLinear = 1'b0;
    rdP("R8", 9); cont("R8", 0); cont("R8", 0); cont("R8", 0); nop();
    // R9 hold
    rdP("R9", 10); cont("R9", 1); cont("R9", 0); cont("R9", 1); nop();
    // R6 blocked processor strobe mid burst, then resume
    burstLinear = 1'b1;
    rdP("R6", 8); cont("R6", 0);
    step("R6", 0, 1, 1, 1, 0, 1, 1, 4'hF, 40, 0);
    cont("R6", 0);
    // R6: controller strobe still works with ce0N high -> deselect
    step("R6", 1, 0, 1, 1, 0, 1, 1, 4'hF, 8, 0);
    cont("R6", 0);
    // R12 deselect ends burst
    rdP("R12", 9); cont("R12", 0); nop(); cont("R12", 0); cont("R12", 1);
    // R12 processor strobe with ceAuxN high deselects
    rdP("R12", 9); step("R12", 0, 1, 1, 0, 1, 1, 1, 4'hF, 9, 0); cont("R12", 0);
    // R10 read then write command on next edge mutes read data
    rdP("R10", 8); wrC("R10", 20, 0, 1, 4'hF, 32'h20202020); nop();
    rdP("R10", 9); step("R10", 1, 1, 1, 0, 1, 1, 0, 4'b1110, 0, 0); nop();
    rdP("R10", 20); nop(); nop();
    // R11 output enable high blanks data
    rdP("R11", 11); nop();
    @(negedge clk); oeN = 1'b1;
    rdP("R11", 10); nop(); nop();
    @(negedge clk); oeN = 1'b0;
    rdP("R11", 10); nop(); nop(); nop();

    repeat (4) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R1: %0d expectations left, expected 0", q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule